// File: doc/BRIEF.md
# Indexed Block-Transfer Configuration Target

This block is a two-wire bus target that owns a small bank of 8-bit configuration registers. It samples the clock and data lines on a fast system clock and finds start, repeated-start and stop conditions. It answers a single fixed 7-bit address and moves data only in indexed block transfers.

A write sends a starting index, then a byte count, then that many data bytes. The bytes land in consecutive registers. A read first sets the index with a short write phase. After a repeated start and the read address, the target returns the count register's value, followed by register contents from the index onward. The register bank drives a set of control fields used by the surrounding clock-distribution logic: per-output enables, per-output stop eligibility, drive modes during power-down and stop, bandwidth, bypass and divider selects. The bank also holds an identification byte, a device identifier and the read byte count.

The data line is only ever pulled low by the block, in open-drain style, and any start or stop aborts the transfer in progress.

Top module: `smbt_target`

## Requirements
- R1: After reset, register 0 is 0x07, register 1 (output enables) is 0xFF, register 2 (stoppable mask) is 0x00, register 3 is 0x00, register 5 (device identifier) is 0x08 and register 6 (read count) is 0x05.
- R2: The target answers 7-bit address 0x6E, with the R/W bit as the LSB, so it ACKs 0xDC (write) and 0xDD (read). Any other address byte is NACKed, and everything up to the next start or stop is ignored and left unacknowledged.
- R3: In a write, after the address the host sends an index N, then a count X, then data. The target ACKs each of these bytes and stores the data bytes in registers N, N+1 and onward.
- R4: Once X data bytes of a write have been taken, further data bytes are NACKed and not stored.
- R5: In a read (write address, index N, repeated start, read address), the first byte returned is the current value of register 6, and the next bytes are registers N, N+1 and onward.
- R6: After as many data bytes as register 6 held at the read address, the target leaves the data line released, so the host sees 0xFF. After a host NACK, the target releases the line and sends nothing more.
- R7: Register 4 is read-only and reads {revision nibble, vendor nibble} = 0x01. Writes to register 4 or to any index of 7 or above are ACKed but change nothing, and reads of index 7 and above return 0x00.
- R8: Register 0 fields: bit 7 selects high-impedance power-down drive, bit 6 selects high-impedance stop drive, bits 5:3 are stored spare bits, bit 2 selects low bandwidth, bit 1 selects the loop (not bypass) path, and bit 0 selects the undivided clock. Bit i of register 1 enables output i, bit i of register 2 makes output i stoppable, register 5 is the device identifier, and register 6 is the read count. A write is visible on the matching port.
- R9: A stop or a start at any point, even within a byte, ends the transfer. A partly received byte is discarded, and a start begins a new address phase.
- R10: The data line is driven only low. The drive is asserted only just after a falling clock edge, and it is never asserted while idle or while ignoring the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | Open-drain pull-down enable for the data line |
| ctl_pd_hiz | output | 1 | Power-down drive mode (1 = high impedance) |
| ctl_stop_hiz | output | 1 | Stop drive mode (1 = high impedance) |
| ctl_rsvd | output | 3 | Spare bits of register 0 |
| ctl_bw_low | output | 1 | Bandwidth select (1 = low) |
| ctl_pll | output | 1 | Path select (1 = loop, 0 = bypass) |
| ctl_div1 | output | 1 | Divider select (1 = undivided, 0 = divide by two) |
| ctl_oe | output | 8 | Per-output enables |
| ctl_stoppable | output | 8 | Per-output stop eligibility |
| dev_id | output | 8 | Device identifier register |
| rd_count | output | 8 | Byte count returned by reads |

## Verification
Two things can happen on the same fast-clock edge at the end of a counted byte. In a write, the last counted byte is committed and the remaining count reaches zero together; in a read, the pointer advances and the read count runs out together. The bench provokes this by sending one data byte more than the count in a write, and by clocking two bytes past the count in a read. It judges the result from the ACK pattern, from the unchanged neighbouring register on the ports, and from 0xFF appearing exactly where the count runs out.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    localparam int REG_W     = 8;
    localparam int IDX_CTRL  = 0;
    localparam int IDX_OE    = 1;
    localparam int IDX_STP   = 2;
    localparam int IDX_SPARE = 3;
    localparam int IDX_ID    = 4;
    localparam int IDX_DEV   = 5;
    localparam int IDX_CNT   = 6;
    localparam int MIN_REGS  = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INDEX,
        PH_COUNT,
        PH_WDATA,
        PH_READ,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic [REG_W-1:0] reg_reset(input int idx,
                                                  input logic [REG_W-1:0] dev_rst,
                                                  input logic [REG_W-1:0] cnt_rst,
                                                  input logic [REG_W-1:0] id_val);
        case (idx)
            IDX_CTRL: return 8'h07;
            IDX_OE:   return 8'hFF;
            IDX_ID:   return id_val;
            IDX_DEV:  return dev_rst;
            IDX_CNT:  return cnt_rst;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic addr_hit(input logic [REG_W-1:0] b, input logic [6:0] a7);
        return b[7:1] == a7;
    endfunction

endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync
    import smbt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    logic [STAGES-1:0] scl_sr, sda_sr;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_in};
            sda_sr <= {sda_sr[STAGES-2:0], sda_in};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign scl_s = scl_sr[STAGES-1];
    assign sda_s = sda_sr[STAGES-1];

    always_comb begin
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/smbt_regbank.sv
module smbt_regbank
    import smbt_pkg::*;
#(
    parameter int               NUM_REGS = 7,
    parameter logic [REG_W-1:0] ID_VAL   = 8'h01,
    parameter logic [REG_W-1:0] DEV_RST  = 8'h08,
    parameter logic [REG_W-1:0] CNT_RST  = 8'h05
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] widx,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] ridx,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] oe_q,
    output logic [REG_W-1:0] stp_q,
    output logic [REG_W-1:0] dev_q,
    output logic [REG_W-1:0] cnt_q
);
    localparam int IDXW = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0][REG_W-1:0] bank_q;
    logic [NUM_REGS-1:0][REG_W-1:0] bank_d;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        if (i == IDX_ID) begin : g_ro
            assign bank_d[i] = ID_VAL;
        end else begin : g_rw
            assign bank_d[i] = (we && widx == REG_W'(i)) ? wdata : bank_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                bank_q[i] <= reg_reset(i, DEV_RST, CNT_RST, ID_VAL);
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rdata  = (ridx < REG_W'(NUM_REGS)) ? bank_q[ridx[IDXW-1:0]] : '0;
    assign ctrl_q = bank_q[IDX_CTRL];
    assign oe_q   = bank_q[IDX_OE];
    assign stp_q  = bank_q[IDX_STP];
    assign dev_q  = bank_q[IDX_DEV];
    assign cnt_q  = bank_q[IDX_CNT];
endmodule

// File: rtl/smbt_engine.sv
module smbt_engine
    import smbt_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h6E
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    input  logic [REG_W-1:0] cnt_val,
    input  logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] ridx,
    output logic             we,
    output logic [REG_W-1:0] widx,
    output logic [REG_W-1:0] wdata,
    output logic             sda_low,
    output phase_e           phase
);
    localparam logic [3:0] BITS = 4'(REG_W);

    logic [3:0]       bit_cnt;
    logic             ack_ph;
    logic             rd_go;
    logic             host_nack;
    logic [REG_W-1:0] shreg;
    logic [REG_W-1:0] ptr;
    logic [REG_W-1:0] wrem;
    logic [REG_W-1:0] rrem;
    logic [REG_W-1:0] tx_next;
    logic             rx_phase;

    assign ridx     = ptr;
    assign tx_next  = (rrem != '0) ? rdata : '1;
    assign rx_phase = (phase == PH_ADDR) || (phase == PH_INDEX) ||
                      (phase == PH_COUNT) || (phase == PH_WDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            ack_ph    <= 1'b0;
            rd_go     <= 1'b0;
            host_nack <= 1'b0;
            shreg     <= '0;
            ptr       <= '0;
            wrem      <= '0;
            rrem      <= '0;
            sda_low   <= 1'b0;
            we        <= 1'b0;
            widx      <= '0;
            wdata     <= '0;
        end else begin
            we <= 1'b0;
            if (ev.start || ev.stop) begin
                phase   <= ev.start ? PH_ADDR : PH_IDLE;
                bit_cnt <= '0;
                ack_ph  <= 1'b0;
                rd_go   <= 1'b0;
                sda_low <= 1'b0;
            end else if (phase == PH_READ) begin
                if (ev.rise) begin
                    if (!ack_ph) bit_cnt <= bit_cnt + 4'd1;
                    else         host_nack <= ev.sda;
                end
                if (ev.fall) begin
                    if (!ack_ph) begin
                        if (bit_cnt != BITS) begin
                            shreg   <= {shreg[REG_W-2:0], 1'b1};
                            sda_low <= ~shreg[REG_W-2];
                        end else begin
                            sda_low <= 1'b0;
                            ack_ph  <= 1'b1;
                        end
                    end else begin
                        ack_ph  <= 1'b0;
                        bit_cnt <= '0;
                        if (host_nack) begin
                            phase   <= PH_SKIP;
                            sda_low <= 1'b0;
                        end else begin
                            shreg   <= tx_next;
                            sda_low <= ~tx_next[REG_W-1];
                            if (rrem != '0) begin
                                ptr  <= ptr + 1'b1;
                                rrem <= rrem - 1'b1;
                            end
                        end
                    end
                end
            end else if (rx_phase) begin
                if (ev.rise && !ack_ph && bit_cnt != BITS) begin
                    shreg   <= {shreg[REG_W-2:0], ev.sda};
                    bit_cnt <= bit_cnt + 4'd1;
                end
                if (ev.fall) begin
                    if (ack_ph) begin
                        ack_ph  <= 1'b0;
                        bit_cnt <= '0;
                        if (rd_go) begin
                            rd_go   <= 1'b0;
                            phase   <= PH_READ;
                            shreg   <= cnt_val;
                            rrem    <= cnt_val;
                            sda_low <= ~cnt_val[REG_W-1];
                        end else begin
                            sda_low <= 1'b0;
                        end
                    end else if (bit_cnt == BITS) begin
                        ack_ph <= 1'b1;
                        case (phase)
                            PH_ADDR: begin
                                if (!addr_hit(shreg, ADDR7)) begin
                                    phase <= PH_SKIP;
                                end else begin
                                    sda_low <= 1'b1;
                                    if (shreg[0]) rd_go <= 1'b1;
                                    else          phase <= PH_INDEX;
                                end
                            end
                            PH_INDEX: begin
                                ptr     <= shreg;
                                phase   <= PH_COUNT;
                                sda_low <= 1'b1;
                            end
                            PH_COUNT: begin
                                wrem    <= shreg;
                                phase   <= PH_WDATA;
                                sda_low <= 1'b1;
                            end
                            PH_WDATA: begin
                                if (wrem != '0) begin
                                    we      <= 1'b1;
                                    widx    <= ptr;
                                    wdata   <= shreg;
                                    ptr     <= ptr + 1'b1;
                                    wrem    <= wrem - 1'b1;
                                    sda_low <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/smbt_target.sv
module smbt_target
    import smbt_pkg::*;
#(
    parameter logic [6:0]       ADDR7       = 7'h6E,
    parameter int               NUM_REGS    = MIN_REGS,
    parameter int               SYNC_STAGES = 2,
    parameter logic [3:0]       REV_ID      = 4'h0,
    parameter logic [3:0]       VENDOR_ID   = 4'h1,
    parameter logic [REG_W-1:0] DEV_RST     = 8'h08,
    parameter logic [REG_W-1:0] CNT_RST     = 8'h05
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_drive_low,
    output logic             ctl_pd_hiz,
    output logic             ctl_stop_hiz,
    output logic [2:0]       ctl_rsvd,
    output logic             ctl_bw_low,
    output logic             ctl_pll,
    output logic             ctl_div1,
    output logic [REG_W-1:0] ctl_oe,
    output logic [REG_W-1:0] ctl_stoppable,
    output logic [REG_W-1:0] dev_id,
    output logic [REG_W-1:0] rd_count
);
    localparam logic [REG_W-1:0] ID_VAL = {REV_ID, VENDOR_ID};

    line_ev_t         line_ev;
    phase_e           phase;
    logic             reg_we;
    logic [REG_W-1:0] reg_widx, reg_wdata, reg_ridx, reg_rdata;
    logic [REG_W-1:0] ctrl_q;

    smbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (line_ev)
    );

    smbt_engine #(.ADDR7(ADDR7)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .ev      (line_ev),
        .cnt_val (rd_count),
        .rdata   (reg_rdata),
        .ridx    (reg_ridx),
        .we      (reg_we),
        .widx    (reg_widx),
        .wdata   (reg_wdata),
        .sda_low (sda_drive_low),
        .phase   (phase)
    );

    smbt_regbank #(
        .NUM_REGS (NUM_REGS),
        .ID_VAL   (ID_VAL),
        .DEV_RST  (DEV_RST),
        .CNT_RST  (CNT_RST)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .widx   (reg_widx),
        .wdata  (reg_wdata),
        .ridx   (reg_ridx),
        .rdata  (reg_rdata),
        .ctrl_q (ctrl_q),
        .oe_q   (ctl_oe),
        .stp_q  (ctl_stoppable),
        .dev_q  (dev_id),
        .cnt_q  (rd_count)
    );

    assign ctl_pd_hiz   = ctrl_q[7];
    assign ctl_stop_hiz = ctrl_q[6];
    assign ctl_rsvd     = ctrl_q[5:3];
    assign ctl_bw_low   = ctrl_q[2];
    assign ctl_pll      = ctrl_q[1];
    assign ctl_div1     = ctrl_q[0];
endmodule

// File: rtl/smbt_target_chk.sv
module smbt_target_chk
    import smbt_pkg::*;
#(
    parameter logic [REG_W-1:0] DEV_RST = 8'h08,
    parameter logic [REG_W-1:0] CNT_RST = 8'h05
) (
    input logic             clk,
    input logic             rst,
    input logic             sda_drive_low,
    input phase_e           phase,
    input line_ev_t         line_ev,
    input logic             reg_we,
    input logic [REG_W-1:0] reg_widx,
    input logic [REG_W-1:0] ctl_oe,
    input logic [REG_W-1:0] ctl_stoppable,
    input logic [REG_W-1:0] dev_id,
    input logic [REG_W-1:0] rd_count
);
    // R1
    reset_values_chk: assert property (@(posedge clk)
        rst |=> (ctl_oe == 8'hFF && ctl_stoppable == 8'h00 &&
                 dev_id == DEV_RST && rd_count == CNT_RST));

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_SKIP) |-> !sda_drive_low);

    // R10
    drive_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> $past(line_ev.fall));

    // R9
    stop_abort_chk: assert property (@(posedge clk) disable iff (rst)
        line_ev.stop |=> (phase == PH_IDLE && !sda_drive_low));

    // R9
    start_abort_chk: assert property (@(posedge clk) disable iff (rst)
        line_ev.start |=> (phase == PH_ADDR && !sda_drive_low));

    // R8
    dev_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dev_id) |-> $past(reg_we && reg_widx == 8'd5));
endmodule

bind smbt_target smbt_target_chk u_chk (.*);

// File: tb/tb_smbt_target.sv
module tb_smbt_target;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    logic sda_drive_low;
    logic ctl_pd_hiz, ctl_stop_hiz, ctl_bw_low, ctl_pll, ctl_div1;
    logic [2:0] ctl_rsvd;
    logic [7:0] ctl_oe, ctl_stoppable, dev_id, rd_count;
    wire  sda_bus = host_sda & ~sda_drive_low;

    int checks = 0;
    int errors = 0;
    localparam int Q = 10;

    logic [7:0] ackv [16];
    logic [7:0] rbuf [16];
    logic [7:0] wbuf [16];
    logic       rel_ok;

    always #2.5 clk = ~clk;

    smbt_target dut (
        .clk(clk), .rst(rst), .scl_in(host_scl), .sda_in(sda_bus),
        .sda_drive_low(sda_drive_low), .ctl_pd_hiz(ctl_pd_hiz),
        .ctl_stop_hiz(ctl_stop_hiz), .ctl_rsvd(ctl_rsvd), .ctl_bw_low(ctl_bw_low),
        .ctl_pll(ctl_pll), .ctl_div1(ctl_div1), .ctl_oe(ctl_oe),
        .ctl_stoppable(ctl_stoppable), .dev_id(dev_id), .rd_count(rd_count)
    );

    // {index, written byte, expected readback}
    localparam logic [23:0] VEC [6] = '{
        {8'd0, 8'hC2, 8'hC2},
        {8'd3, 8'h5A, 8'h5A},
        {8'd4, 8'hEE, 8'h01},
        {8'd7, 8'h33, 8'h00},
        {8'd5, 8'h3C, 8'h3C},
        {8'd1, 8'h0F, 8'h0F}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; qwait();
        host_scl = 1'b1; qwait();
        host_sda = 1'b0; qwait();
        host_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; qwait();
        host_scl = 1'b1; qwait();
        host_sda = 1'b1; qwait();
    endtask

    task automatic put_bit(input logic b);
        host_sda = b;    qwait();
        host_scl = 1'b1; qwait();
        host_scl = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        host_sda = 1'b1; qwait();
        host_scl = 1'b1; qwait();
        b = sda_bus;
        host_scl = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    // ackv: [0] address, [1] index, [2] count, [3+k] data byte k
    task automatic wr_block(input logic [7:0] idx, input logic [7:0] cnt, input int n);
        logic a;
        bus_start();
        send_byte(8'hDC, a); ackv[0] = {7'd0, a};
        send_byte(idx, a);   ackv[1] = {7'd0, a};
        send_byte(cnt, a);   ackv[2] = {7'd0, a};
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            ackv[3+k] = {7'd0, a};
        end
        bus_stop();
    endtask

    // rbuf[0] is the count byte, rbuf[1..n] data; last byte NACKed
    task automatic rd_block(input logic [7:0] idx, input int n);
        logic a;
        bus_start();
        send_byte(8'hDC, a); ackv[0] = {7'd0, a};
        send_byte(idx, a);   ackv[1] = {7'd0, a};
        bus_start();
        send_byte(8'hDD, a); ackv[2] = {7'd0, a};
        recv_byte(1'b1, rbuf[0]);
        for (int k = 1; k <= n; k++) recv_byte(k != n, rbuf[k]);
        host_sda = 1'b1; qwait();
        rel_ok = sda_bus;
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic a;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 ctrl fields", {ctl_pd_hiz, ctl_stop_hiz, ctl_rsvd, ctl_bw_low, ctl_pll, ctl_div1}, 8'h07);
        chk("R1 oe", ctl_oe, 8'hFF);
        chk("R1 stoppable", ctl_stoppable, 8'h00);
        chk("R1 dev id", dev_id, 8'h08);
        chk("R1 count", rd_count, 8'h05);
        chk("R10 idle released", {7'd0, sda_bus}, 8'h01);

        // vector table: single-byte write then block read back
        for (int v = 0; v < 6; v++) begin
            wbuf[0] = VEC[v][15:8];
            wr_block(VEC[v][23:16], 8'd1, 1);
            chk("R3 R7 write acks", {ackv[0][0], ackv[1][0], ackv[2][0], ackv[3][0]}, 8'h0F);
            rd_block(VEC[v][23:16], 1);
            chk("R2 read address ack", ackv[2], 8'h01);
            chk("R5 count byte first", rbuf[0], 8'h05);
            chk("R5 R7 readback", rbuf[1], VEC[v][7:0]);
        end

        // R8 field mapping from table values (reg0 = C2, reg1 = 0F)
        chk("R8 fields", {ctl_pd_hiz, ctl_stop_hiz, ctl_rsvd, ctl_bw_low, ctl_pll, ctl_div1}, 8'hC2);
        chk("R8 pd hiz", {7'd0, ctl_pd_hiz}, 8'h01);
        chk("R8 oe", ctl_oe, 8'h0F);
        chk("R8 dev id", dev_id, 8'h3C);

        // R2 wrong address ignored
        bus_start();
        send_byte(8'hA0, a); chk("R2 foreign address nack", {7'd0, a}, 8'h00);
        send_byte(8'h01, a); chk("R2 ignored index", {7'd0, a}, 8'h00);
        chk("R10 skip released", {7'd0, sda_bus}, 8'h00 | {7'd0, host_sda});
        send_byte(8'h01, a);
        send_byte(8'h00, a); chk("R2 ignored data", {7'd0, a}, 8'h00);
        bus_stop();
        chk("R2 oe untouched", ctl_oe, 8'h0F);

        // R3 multi-byte write
        wbuf[0] = 8'hAA; wbuf[1] = 8'h55;
        wr_block(8'd1, 8'd2, 2);
        chk("R3 acks", {ackv[3][0], ackv[4][0]}, 8'h03);
        chk("R3 oe", ctl_oe, 8'hAA);
        chk("R3 stoppable", ctl_stoppable, 8'h55);

        // R4 byte past count refused
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        wr_block(8'd5, 8'd1, 2);
        chk("R4 counted byte ack", ackv[3], 8'h01);
        chk("R4 extra byte nack", ackv[4], 8'h00);
        chk("R4 dev id", dev_id, 8'h11);
        chk("R4 neighbour untouched", rd_count, 8'h05);

        // R5 R6 count register sets read length
        wbuf[0] = 8'h03;
        wr_block(8'd6, 8'd1, 1);
        chk("R8 count port", rd_count, 8'h03);
        rd_block(8'd0, 5);
        chk("R5 count byte", rbuf[0], 8'h03);
        chk("R5 data idx0", rbuf[1], 8'hC2);
        chk("R5 data idx1", rbuf[2], 8'hAA);
        chk("R5 data idx2", rbuf[3], 8'h55);
        chk("R6 past count", rbuf[4], 8'hFF);
        chk("R6 past count 2", rbuf[5], 8'hFF);
        chk("R6 released after nack", {7'd0, rel_ok}, 8'h01);

        // R7 read running past the last index
        rd_block(8'd5, 3);
        chk("R7 idx5", rbuf[1], 8'h11);
        chk("R7 idx6", rbuf[2], 8'h03);
        chk("R7 idx7 zero", rbuf[3], 8'h00);

        // R9 stop inside a data byte
        bus_start();
        send_byte(8'hDC, a); send_byte(8'd5, a); send_byte(8'd1, a);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        chk("R9 stop abort dev id", dev_id, 8'h11);

        // R9 repeated start inside a count byte, then a fresh write
        bus_start();
        send_byte(8'hDC, a); send_byte(8'd5, a);
        for (int i = 0; i < 3; i++) put_bit(1'b0);
        bus_start();
        send_byte(8'hDC, a); chk("R9 new address ack", {7'd0, a}, 8'h01);
        send_byte(8'd2, a); send_byte(8'd1, a);
        send_byte(8'h99, a);
        bus_stop();
        chk("R9 restart write", ctl_stoppable, 8'h99);
        chk("R9 aborted target untouched", dev_id, 8'h11);
        chk("R10 idle after stop", {7'd0, sda_bus}, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule